// File: doc/BRIEF.md
# Banked TLB Register Access Port

This block sits next to a processor's special-register file and lets software manage a small TLB held in two of the four special-register banks. A two-bit bank selector picks the active bank. Banks 0 and 3 are ordinary 16-word register banks. Banks 1 and 2 each own their own TLB of 4 sets by 16 entries, and each entry holds a 32-bit high word and a 32-bit low word. In those two banks some register numbers have side effects. A selector register picks the entry: its bits [3:0] give the index and its bits [5:4] give the set. A write to the high-word register is also copied into a cause register. A write to the low-word register commits a whole entry, taking its high word from the cause register.

When a commit replaces an entry whose valid bit was set, the block queues a page-invalidate request for the old page. The same happens for the old and the new value of a single-step address register whenever that register is rewritten. A separate request compares a proposed process ID with the current one and raises a flush for the current ID when the two differ. Invalidates leave the block as single-cycle pulses from a small queue, one per cycle.

Top module: `banked_tlb_port`

## Requirements
- R1: After reset `rd_valid`, `inv_valid` and `flush_valid` are low and every TLB entry reads as zero (invalid).
- R2: A read (`rd_en`) returns its data on `rd_data` with `rd_valid` high in the cycle after the strobe. In banks 0 and 3 a read returns the register's contents, including register numbers 5 and 6, with no side effect.
- R3: Each of the four banks has its own registers; a write in one bank does not change the same register number in another bank.
- R4: In banks 1 and 2 a write to register 6 (high word) also stores the data in register 3 (cause). In banks 0 and 3 such a write leaves register 3 unchanged.
- R5: In banks 1 and 2 a write to register 5 (low word) commits the entry chosen by register 4 (index = bits [3:0], set = bits [5:4]): low word = written data, high word = the bank's register 3.
- R6: If the entry being replaced had bit 3 of its low word set, one invalidate is issued with address = old high word with bits [12:0] cleared (page-offset width 13). If that bit was clear, no invalidate is issued.
- R7: In banks 1 and 2 any read first reloads registers 6 and 5 from the selected entry. A read of 6 or 5 therefore returns the entry's high or low word even after a plain write to register 6.
- R8: Bank 1 uses TLB array 0 and bank 2 uses TLB array 1; the two arrays are independent.
- R9: A PID request raises `flush_valid` for one cycle, the cycle after the request, carrying the low 8 bits of `cur_pid`. This happens only when the low 8 bits of `pid_new` differ from those of `cur_pid`; upper bits are ignored.
- R10: A write of the step address issues an invalidate for the previous step address in the next cycle and one for the new address in the cycle after. The previous address is zero after reset.
- R11: Invalidates are single-cycle pulses, one per cycle. Those caused in the same cycle leave in this order: TLB commit, old step address, new step address.
- R12: When `wr_en` and `rd_en` are high together, the write is performed and the read is dropped (no `rd_valid`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 2 | Active special-register bank |
| wr_en | input | 1 | Special-register write strobe |
| wr_idx | input | 4 | Register number written |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Special-register read strobe (ignored while wr_en is high) |
| rd_idx | input | 4 | Register number read |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| cur_pid | input | 32 | Current process-ID register |
| pid_req | input | 1 | PID change request |
| pid_new | input | 32 | Requested process ID |
| flush_valid | output | 1 | Flush-by-PID pulse |
| flush_pid | output | 8 | PID to flush |
| step_wr | input | 1 | Step-address write strobe |
| step_addr | input | 32 | New step address |
| inv_valid | output | 1 | Page-invalidate pulse |
| inv_addr | output | 32 | Page-invalidate address |

## Verification
Several properties are checked on every cycle: read strobes map to `rd_valid` one cycle later (and a read that collides with a write is dropped), a matching PID never produces a flush, a step write or a commit over a valid entry always yields an invalidate in the next cycle, and the invalidate queue never overflows. The contents of the register banks and the TLB arrays can only be seen through the read port, so the bench scenarios have to show the value-level behaviour. That covers the cause mirror, which entry a commit reaches, the page address cut from the old high word, the independence of the two arrays, and the exact order of invalidates when a commit and a step write coincide.

// File: rtl/tlb_port_pkg.sv
package tlb_port_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_inval_queue.sv
// Multi-push, single-pop queue of invalidate addresses. Head is a register.
module tlb_inval_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int NPUSH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPUSH-1:0] push_v,
  input  logic [W-1:0]     push_d [NPUSH],
  output logic             out_v,
  output logic [W-1:0]     out_d
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] dst [NPUSH];
  logic [CNT_W-1:0] n_push;
  logic             pop;

  // Lower push ports land first: this fixes the output order.
  always_comb begin
    n_push = '0;
    for (int i = 0; i < NPUSH; i++) begin
      dst[i] = wp + PTR_W'(n_push);
      n_push = n_push + CNT_W'(push_v[i]);
    end
  end

  assign pop = (cnt != '0);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPUSH; i++) begin
      if (push_v[i]) slots[dst[i]] <= push_d[i];
    end
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp + PTR_W'(n_push);
      if (pop) rp <= rp + PTR_W'(1);
      cnt <= cnt + n_push - CNT_W'(pop);
    end
  end

  assign out_v = (cnt != '0);
  assign out_d = slots[rp];

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ((CNT_W+1)'(cnt) + (CNT_W+1)'(n_push)) <= ((CNT_W+1)'(DEPTH) + (CNT_W+1)'(pop)));
endmodule

// File: rtl/tlb_entry_store.sv
// TLB arrays, flattened as {array, set, index}; one read port, one write port.
module tlb_entry_store
  import tlb_port_pkg::*;
#(
  parameter int NARR = 2,
  parameter int SETS = 4,
  parameter int ENTS = 16,
  localparam int DEPTH = NARR * SETS * ENTS,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [AW-1:0] rd_addr,
  output tlb_entry_t rd_entry,
  input  logic       wr_en,
  input  logic [AW-1:0] wr_addr,
  input  tlb_entry_t wr_entry
);
  tlb_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_entry;
    end
  end

  assign rd_entry = mem[rd_addr];
endmodule

// File: rtl/banked_tlb_port.sv
module banked_tlb_port
  import tlb_port_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int NREG      = 16,
  parameter int SETS      = 4,
  parameter int ENTS      = 16,
  parameter int PAGE_W    = 13,
  parameter int VALID_BIT = 3,
  parameter int PID_W     = 8,
  parameter int QDEPTH    = 8,
  parameter int SEL_IDX   = 4,
  parameter int LO_IDX    = 5,
  parameter int HI_IDX    = 6,
  parameter int CAUSE_IDX = 3,
  localparam int DW    = WORD_W,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  input  logic [DW-1:0]     cur_pid,
  input  logic              pid_req,
  input  logic [DW-1:0]     pid_new,
  output logic              flush_valid,
  output logic [PID_W-1:0]  flush_pid,
  input  logic              step_wr,
  input  logic [DW-1:0]     step_addr,
  output logic              inv_valid,
  output logic [DW-1:0]     inv_addr
);
  localparam int NBANK = 1 << BANK_W;
  localparam int NTLB  = 2;
  localparam int ARR_W = $clog2(NTLB);
  localparam int SET_W = $clog2(SETS);
  localparam int IX_W  = $clog2(ENTS);
  localparam int EA_W  = ARR_W + SET_W + IX_W;

  logic [DW-1:0] sregs [NBANK][NREG];
  logic [DW-1:0] step_q;

  logic [DW-1:0]     sel_word;
  logic              tlb_bank;
  logic [BANK_W-1:0] bank_m1;
  logic [EA_W-1:0]   ent_addr;
  logic              commit;
  tlb_entry_t        old_ent, new_ent;
  logic [2:0]        push_v;
  logic [DW-1:0]     push_d [3];

  assign sel_word = sregs[bank_sel][SEL_IDX];
  assign tlb_bank = (bank_sel == BANK_W'(1)) || (bank_sel == BANK_W'(2));
  assign bank_m1  = bank_sel - BANK_W'(1);
  assign ent_addr = {bank_m1[ARR_W-1:0], sel_word[IX_W +: SET_W], sel_word[IX_W-1:0]};
  assign commit   = wr_en && tlb_bank && (wr_idx == IDX_W'(LO_IDX));
  assign new_ent.hi = sregs[bank_sel][CAUSE_IDX];
  assign new_ent.lo = wr_data;

  tlb_entry_store #(.NARR(NTLB), .SETS(SETS), .ENTS(ENTS)) store_i (
    .clk      (clk),
    .rst      (rst),
    .rd_addr  (ent_addr),
    .rd_entry (old_ent),
    .wr_en    (commit),
    .wr_addr  (ent_addr),
    .wr_entry (new_ent)
  );

  // Port order sets the emission order: commit, old step, new step.
  assign push_v    = {step_wr, step_wr, commit && old_ent.lo[VALID_BIT]};
  assign push_d[0] = {old_ent.hi[DW-1:PAGE_W], {PAGE_W{1'b0}}};
  assign push_d[1] = step_q;
  assign push_d[2] = step_addr;

  tlb_inval_queue #(.W(DW), .DEPTH(QDEPTH), .NPUSH(3)) queue_i (
    .clk    (clk),
    .rst    (rst),
    .push_v (push_v),
    .push_d (push_d),
    .out_v  (inv_valid),
    .out_d  (inv_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBANK; b++)
        for (int r = 0; r < NREG; r++) sregs[b][r] <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      flush_valid <= 1'b0;
      flush_pid   <= '0;
      step_q      <= '0;
    end else begin
      rd_valid    <= 1'b0;
      flush_valid <= pid_req && (pid_new[PID_W-1:0] != cur_pid[PID_W-1:0]);
      flush_pid   <= cur_pid[PID_W-1:0];
      if (step_wr) step_q <= step_addr;
      if (wr_en) begin
        sregs[bank_sel][wr_idx] <= wr_data;
        if (tlb_bank && wr_idx == IDX_W'(HI_IDX))
          sregs[bank_sel][CAUSE_IDX] <= wr_data;
      end else if (rd_en) begin
        rd_valid <= 1'b1;
        if (tlb_bank) begin
          sregs[bank_sel][HI_IDX] <= old_ent.hi;
          sregs[bank_sel][LO_IDX] <= old_ent.lo;
          if (rd_idx == IDX_W'(HI_IDX))      rd_data <= old_ent.hi;
          else if (rd_idx == IDX_W'(LO_IDX)) rd_data <= old_ent.lo;
          else                               rd_data <= sregs[bank_sel][rd_idx];
        end else begin
          rd_data <= sregs[bank_sel][rd_idx];
        end
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_valid && !inv_valid && !flush_valid));
  // R2 R12
  rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(rd_en) && !$past(wr_en)));
  // R9
  pid_match_chk: assert property (@(posedge clk) disable iff (rst)
    (pid_req && pid_new[PID_W-1:0] == cur_pid[PID_W-1:0]) |=> !flush_valid);
  // R10
  step_inval_chk: assert property (@(posedge clk) disable iff (rst)
    step_wr |=> inv_valid);
  // R6
  stale_inval_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && old_ent.lo[VALID_BIT]) |=> inv_valid);
endmodule

// File: tb/banked_tlb_port_tb_top.sv
module banked_tlb_port_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  bank_sel;
  logic        wr_en, rd_en, pid_req, step_wr;
  logic [3:0]  wr_idx, rd_idx;
  logic [31:0] wr_data, cur_pid, pid_new, step_addr;
  logic        rd_valid, flush_valid, inv_valid;
  logic [31:0] rd_data, inv_addr;
  logic [7:0]  flush_pid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  banked_tlb_port dut_i (
    .clk(clk), .rst(rst), .bank_sel(bank_sel),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .cur_pid(cur_pid), .pid_req(pid_req), .pid_new(pid_new),
    .flush_valid(flush_valid), .flush_pid(flush_pid),
    .step_wr(step_wr), .step_addr(step_addr),
    .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] b, logic [3:0] i, logic [31:0] d);
    @(negedge clk);
    bank_sel = b; wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] b, logic [3:0] i, logic [31:0] exp, string tag);
    @(negedge clk);
    bank_sel = b; rd_en = 1'b1; rd_idx = i;
    @(negedge clk);
    rd_en = 1'b0;
    check({tag, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
    check({tag, " rd_data"}, rd_data, exp);
  endtask

  task automatic no_inv(string tag);
    check({tag, " no invalidate"}, {31'd0, inv_valid}, 32'd0);
  endtask

  task automatic inv_is(string tag, logic [31:0] a);
    check({tag, " inv_valid"}, {31'd0, inv_valid}, 32'd1);
    check({tag, " inv_addr"}, inv_addr, a);
  endtask

  task automatic t_reset;
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R1 inv_valid", {31'd0, inv_valid}, 32'd0);
    check("R1 flush_valid", {31'd0, flush_valid}, 32'd0);
    rd(2'd1, 4'd6, 32'h0, "R1 entry hi zero");
    rd(2'd2, 4'd5, 32'h0, "R1 entry lo zero");
  endtask

  task automatic t_plain;
    wr(2'd0, 4'd2, 32'hA5A5_0001);
    wr(2'd3, 4'd2, 32'h0000_3333);
    rd(2'd0, 4'd2, 32'hA5A5_0001, "R3 bank0 kept");
    rd(2'd3, 4'd2, 32'h0000_3333, "R3 bank3 kept");
    wr(2'd0, 4'd5, 32'h0000_0008);
    no_inv("R2 bank0 lo write");
    rd(2'd0, 4'd5, 32'h0000_0008, "R2 bank0 reg5 plain");
    wr(2'd0, 4'd6, 32'hCAFE_0000);
    rd(2'd0, 4'd3, 32'h0, "R4 bank0 no cause mirror");
    rd(2'd0, 4'd6, 32'hCAFE_0000, "R2 bank0 reg6 plain");
  endtask

  task automatic t_commit;
    wr(2'd1, 4'd6, 32'h1234_E000);
    rd(2'd1, 4'd3, 32'h1234_E000, "R4 cause mirror");
    wr(2'd1, 4'd4, 32'h0000_0025);
    wr(2'd1, 4'd6, 32'h0040_3FFF);
    wr(2'd1, 4'd5, 32'h0000_0008);
    no_inv("R6 commit over invalid");
    rd(2'd1, 4'd6, 32'h0040_3FFF, "R5 entry hi");
    rd(2'd1, 4'd5, 32'h0000_0008, "R5 entry lo");
    wr(2'd1, 4'd6, 32'hDEAD_0000);
    rd(2'd1, 4'd6, 32'h0040_3FFF, "R7 reload hides reg write");
    rd(2'd1, 4'd3, 32'hDEAD_0000, "R4 cause after plain hi write");
  endtask

  task automatic t_replace;
    wr(2'd1, 4'd6, 32'h0080_0000);
    wr(2'd1, 4'd5, 32'h0000_0000);
    inv_is("R6 stale page", 32'h0040_2000);
    @(negedge clk);
    no_inv("R11 single pulse");
    rd(2'd1, 4'd6, 32'h0080_0000, "R5 replaced hi");
    wr(2'd1, 4'd5, 32'h0000_0008);
    no_inv("R6 replaced entry was invalid");
    wr(2'd1, 4'd4, 32'h0000_0005);
    rd(2'd1, 4'd6, 32'h0, "R5 set field selects");
    wr(2'd1, 4'd4, 32'h0000_0025);
  endtask

  task automatic t_banks;
    wr(2'd2, 4'd4, 32'h0000_0025);
    rd(2'd2, 4'd6, 32'h0, "R8 array1 untouched");
    wr(2'd2, 4'd6, 32'h1111_0000);
    wr(2'd2, 4'd5, 32'h0000_0008);
    rd(2'd2, 4'd5, 32'h0000_0008, "R8 array1 lo");
    rd(2'd1, 4'd6, 32'h0080_0000, "R8 array0 kept");
  endtask

  task automatic t_pid;
    cur_pid = 32'h0000_0042;
    @(negedge clk);
    pid_req = 1'b1; pid_new = 32'hFFFF_FF42;
    @(negedge clk);
    pid_req = 1'b0;
    check("R9 same low byte no flush", {31'd0, flush_valid}, 32'd0);
    pid_req = 1'b1; pid_new = 32'h0000_0043;
    @(negedge clk);
    pid_req = 1'b0;
    check("R9 flush raised", {31'd0, flush_valid}, 32'd1);
    check("R9 flush pid", {24'd0, flush_pid}, 32'h42);
    @(negedge clk);
    check("R9 flush one cycle", {31'd0, flush_valid}, 32'd0);
  endtask

  task automatic t_step;
    for (int k = 1; k <= 2; k++) begin
      @(negedge clk);
      step_wr = 1'b1; step_addr = 32'h1000_0000 * k;
      @(negedge clk);
      step_wr = 1'b0;
      inv_is("R10 old step", (k == 1) ? 32'h0 : 32'h1000_0000);
      @(negedge clk);
      inv_is("R10 new step", 32'h1000_0000 * k);
      @(negedge clk);
      no_inv("R10 two pulses only");
    end
  endtask

  task automatic t_order;
    wr(2'd2, 4'd6, 32'h0);
    @(negedge clk);
    bank_sel = 2'd2; wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h0;
    step_wr = 1'b1; step_addr = 32'h3000_0000;
    @(negedge clk);
    wr_en = 1'b0; step_wr = 1'b0;
    inv_is("R11 first commit", 32'h1111_0000);
    @(negedge clk);
    inv_is("R11 second old step", 32'h2000_0000);
    @(negedge clk);
    inv_is("R11 third new step", 32'h3000_0000);
    @(negedge clk);
    no_inv("R11 drained");
  endtask

  task automatic t_collide;
    @(negedge clk);
    bank_sel = 2'd0; wr_en = 1'b1; wr_idx = 4'd7; wr_data = 32'h7777_0007;
    rd_en = 1'b1; rd_idx = 4'd7;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R12 read dropped", {31'd0, rd_valid}, 32'd0);
    rd(2'd0, 4'd7, 32'h7777_0007, "R12 write taken");
  endtask

  initial begin
    rst = 1'b1; bank_sel = '0; wr_en = 0; rd_en = 0; pid_req = 0; step_wr = 0;
    wr_idx = '0; rd_idx = '0; wr_data = '0; cur_pid = '0; pid_new = '0; step_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_commit();
    t_replace();
    t_banks();
    t_pid();
    t_step();
    t_order();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule